// File: doc/BRIEF.md
# Raster Timing and Fetch Slot Sequencer

This block is the timebase of a tile-based video processor. It counts master clock cycles into a position within the current line and a line number within the frame. It also splits every line into fixed 8-cycle memory slots and names the external access each slot makes. Downstream address generators and pixel pipelines use the slot kind and the strobe to decide what to read and when. They use the line number, the dummy-line indicator and the vertical-interval flag to order their work across the frame.

Each frame has four phases in this order: a run of vertical-interval lines with no memory traffic, one dummy pre-render line, the visible lines, and one idle line. When the idle line ends, the vertical-interval flag is set and an interrupt pulse can be raised. The processor may be told to stop rendering; it then makes no fetches at all. On every second rendered frame the dummy line drops its final four idle cycles. All counts are parameters; the defaults give 1364-cycle lines and 262-line frames.

Top module: `raster_fetch_seq`

## Requirements
- R1: The cycle counter `dot_num` runs 0 to 1363 on a normal line and then wraps to 0 while `line_num` advances. A frame whose dummy line has full length is 262 lines, which is 357368 cycles.
- R2: `slot_num` equals dot/8 for dots 0 to 1359 and holds 170 during the closing idle cycles. `fetch_strobe` is high only on the first cycle of a slot that makes a fetch (dot a multiple of 8).
- R3: `fetch_kind` encodes idle as 0, name as 1, attribute as 2, pattern low as 3, pattern high as 4, sprite pattern as 5 and discarded name as 6. In slots 0 to 127, slot mod 4 gives name, attribute, pattern low, pattern high.
- R4: In slots 128 to 159, slot mod 4 values 0 and 1 give a discarded name fetch, and values 2 and 3 give a sprite pattern fetch.
- R5: Slots 160 to 167 repeat the background order of R3. Slots 168 and 169 are name fetches. Dots 1360 and later are idle (kind 0).
- R6: Lines 0 to 19 form the vertical interval. Line 20 is the dummy line, on which `dummy_line` is 1. Lines 21 to 260 are visible and line 261 is idle. No fetch occurs on the vertical-interval lines or on the idle line.
- R7: While `render_en` is 0, `fetch_kind` is 0 and `fetch_strobe` is 0 in the same cycle, on every line.
- R8: A frame counts as rendered if `render_en` is 1 on the first cycle of its dummy line. A parity bit toggles at the end of a rendered frame's dummy line and nowhere else. The dummy line lasts 1360 cycles when the frame is rendered and the parity is odd; the first rendered frame after reset has even parity. Otherwise the dummy line lasts 1364 cycles.
- R9: `vblank` becomes 1 on the first cycle of line 0 that follows the idle line. It stays 1 until the cycle after `vbl_clear` is sampled high, or until the dummy line begins. If a set and a clear fall in the same cycle, the set wins.
- R10: `vbl_irq` is a one-cycle pulse that coincides with the rise of `vblank`. It occurs only when `irq_en` is 1 on the last cycle of the idle line.
- R11: After reset the block is at line 0, dot 0, slot 0, with `vblank` and `vbl_irq` low and the parity even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| render_en | input | 1 | Background or sprite rendering is switched on |
| irq_en | input | 1 | Allows the vertical-interval interrupt pulse |
| vbl_clear | input | 1 | Clears the vertical-interval flag |
| line_num | output | LINE_W (9) | Line within the frame |
| dot_num | output | DOT_W (11) | Cycle within the line |
| slot_num | output | SLOT_W (8) | Fetch slot index, 170 during the closing idle cycles |
| fetch_kind | output | 3 | Kind of access made in the current slot |
| fetch_strobe | output | 1 | First cycle of a slot that fetches |
| vblank | output | 1 | Vertical-interval flag |
| vbl_irq | output | 1 | One-cycle interrupt pulse |
| dummy_line | output | 1 | Current line is the pre-render dummy line |

## Verification
The bench shortens the frame to three vertical-interval lines and four visible lines. It keeps the full slot map, so that every dot of a line can be compared with a slot table written as ranges. Four frames are driven in turn. A first rendered frame gives a full dummy line. A second rendered frame gives a shortened one. A third frame has rendering off, which shows that fetches are suppressed and that the dummy line keeps its full length. A fourth rendered frame shows that the parity did not move on the unrendered frame. Along the way the vertical-interval flag is cleared once by `vbl_clear` and once by the start of the dummy line. The interrupt is seen both enabled and masked.

// File: rtl/raster_pkg.sv
package raster_pkg;

  typedef enum logic [2:0] {
    FK_IDLE     = 3'd0,
    FK_NAME     = 3'd1,
    FK_ATTR     = 3'd2,
    FK_PAT_LO   = 3'd3,
    FK_PAT_HI   = 3'd4,
    FK_SPR_PAT  = 3'd5,
    FK_NAME_DIS = 3'd6
  } fetch_kind_t;

  // Number of fetch slots in one line.
  function automatic int slots_per_line(int bg, int spr, int pre, int tail);
    return 4 * (bg + spr + pre) + tail;
  endfunction

  // Cycles in a full-length line.
  function automatic int cycles_per_line(int slot_cycles, int nslots, int idle);
    return slot_cycles * nslots + idle;
  endfunction

  // Background group order: name, attribute, pattern low, pattern high.
  function automatic fetch_kind_t bg_kind(int sub);
    case (sub)
      0:       return FK_NAME;
      1:       return FK_ATTR;
      2:       return FK_PAT_LO;
      default: return FK_PAT_HI;
    endcase
  endfunction

  // Slot index to access kind over the background, sprite, prefetch and tail phases.
  function automatic fetch_kind_t slot_kind(int slot, int bg, int spr, int pre, int tail);
    int bg_end;
    int spr_end;
    int pre_end;
    int tail_end;
    int sub;
    bg_end   = 4 * bg;
    spr_end  = bg_end + 4 * spr;
    pre_end  = spr_end + 4 * pre;
    tail_end = pre_end + tail;
    sub      = slot % 4;
    if (slot < bg_end)        return bg_kind(sub);
    else if (slot < spr_end)  return (sub < 2) ? FK_NAME_DIS : FK_SPR_PAT;
    else if (slot < pre_end)  return bg_kind(sub);
    else if (slot < tail_end) return FK_NAME;
    else                      return FK_IDLE;
  endfunction

endpackage

// File: rtl/raster_dot_counter.sv
module raster_dot_counter #(
  parameter int SLOT_CYCLES = 8,
  parameter int NSLOTS      = 170,
  parameter int LINE_CYCLES = 1364,
  parameter int TRIM_CYCLES = 4,
  parameter int DOT_W       = 11,
  parameter int SLOT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trim,
  output logic [DOT_W-1:0]  dot,
  output logic [SLOT_W-1:0] slot,
  output logic              slot_first,
  output logic              line_end
);

  localparam int PH_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;

  logic [PH_W-1:0]  phase;
  logic [DOT_W-1:0] last_dot;
  logic             phase_wrap;

  always_comb begin
    last_dot   = trim ? DOT_W'(LINE_CYCLES - TRIM_CYCLES - 1) : DOT_W'(LINE_CYCLES - 1);
    line_end   = (dot == last_dot);
    phase_wrap = (phase == PH_W'(SLOT_CYCLES - 1));
    slot_first = (phase == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot   <= '0;
      phase <= '0;
      slot  <= '0;
    end else if (line_end) begin
      dot   <= '0;
      phase <= '0;
      slot  <= '0;
    end else begin
      dot <= dot + 1'b1;
      if (phase_wrap) begin
        phase <= '0;
        if (slot != SLOT_W'(NSLOTS)) slot <= slot + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  AST_DOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dot < DOT_W'(LINE_CYCLES)); // R1
  AST_DOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (dot == '0 && slot == '0)); // R1
  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_wrap && slot < SLOT_W'(NSLOTS) && !line_end) |=> (slot == $past(slot) + 1'b1)); // R2
  AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= SLOT_W'(NSLOTS)); // R2

endmodule

// File: rtl/raster_line_counter.sv
module raster_line_counter #(
  parameter int VBL_LINES = 20,
  parameter int VIS_LINES = 240,
  parameter int NLINES    = 262,
  parameter int LINE_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic              line_first,
  input  logic              render_en,
  output logic [LINE_W-1:0] line,
  output logic              in_dummy,
  output logic              in_visible,
  output logic              blank_start,
  output logic              dummy_start,
  output logic              trim
);

  localparam int DUMMY_LINE = VBL_LINES;
  localparam int IDLE_LINE  = NLINES - 1;

  logic odd_frame;
  logic frame_rendered;

  always_comb begin
    in_dummy    = (line == LINE_W'(DUMMY_LINE));
    in_visible  = (line > LINE_W'(DUMMY_LINE)) && (line < LINE_W'(IDLE_LINE));
    blank_start = line_end && (line == LINE_W'(IDLE_LINE));
    dummy_start = line_end && (line == LINE_W'(DUMMY_LINE - 1));
    trim        = in_dummy && frame_rendered && odd_frame;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line           <= '0;
      odd_frame      <= 1'b0;
      frame_rendered <= 1'b0;
    end else begin
      if (in_dummy && line_first) frame_rendered <= render_en;
      if (line_end) begin
        line <= (line == LINE_W'(IDLE_LINE)) ? '0 : line + 1'b1;
        if (in_dummy && frame_rendered) odd_frame <= ~odd_frame;
      end
    end
  end

  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    line < LINE_W'(NLINES)); // R6
  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    blank_start |=> (line == '0)); // R6
  AST_PARITY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_end && in_dummy) |=> $stable(odd_frame)); // R8
  AST_ONE_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(line)); // R1

endmodule

// File: rtl/raster_slot_decoder.sv
module raster_slot_decoder
  import raster_pkg::*;
#(
  parameter int BG_GROUPS  = 32,
  parameter int SPR_GROUPS = 8,
  parameter int PRE_GROUPS = 2,
  parameter int TAIL_NAMES = 2,
  parameter int SLOT_W     = 8
) (
  input  logic              render_en,
  input  logic              fetch_line,
  input  logic [SLOT_W-1:0] slot,
  input  logic              slot_first,
  output fetch_kind_t       kind,
  output logic              strobe
);

  fetch_kind_t map_kind;

  always_comb begin
    map_kind = slot_kind(int'(slot), BG_GROUPS, SPR_GROUPS, PRE_GROUPS, TAIL_NAMES);
    kind     = (render_en && fetch_line) ? map_kind : FK_IDLE;
    strobe   = (kind != FK_IDLE) && slot_first;
  end

endmodule

// File: rtl/raster_vblank.sv
module raster_vblank (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic dummy_start,
  input  logic clear_req,
  input  logic irq_en,
  output logic flag,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (set_evt) flag <= 1'b1;
      else if (dummy_start || clear_req) flag <= 1'b0;
      irq <= set_evt && irq_en;
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R10
  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag); // R10
  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clear_req && !dummy_start) |=> flag); // R9
  AST_FLAG_RISES_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set_evt)); // R9

endmodule

// File: rtl/raster_fetch_seq.sv
module raster_fetch_seq
  import raster_pkg::*;
#(
  parameter int SLOT_CYCLES = 8,
  parameter int BG_GROUPS   = 32,
  parameter int SPR_GROUPS  = 8,
  parameter int PRE_GROUPS  = 2,
  parameter int TAIL_NAMES  = 2,
  parameter int IDLE_CYCLES = 4,
  parameter int VBL_LINES   = 20,
  parameter int VIS_LINES   = 240,
  localparam int NSLOTS      = slots_per_line(BG_GROUPS, SPR_GROUPS, PRE_GROUPS, TAIL_NAMES),
  localparam int LINE_CYCLES = cycles_per_line(SLOT_CYCLES, NSLOTS, IDLE_CYCLES),
  localparam int NLINES      = VBL_LINES + VIS_LINES + 2,
  localparam int LINE_W      = $clog2(NLINES),
  localparam int DOT_W       = $clog2(LINE_CYCLES),
  localparam int SLOT_W      = $clog2(NSLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              render_en,
  input  logic              irq_en,
  input  logic              vbl_clear,
  output logic [LINE_W-1:0] line_num,
  output logic [DOT_W-1:0]  dot_num,
  output logic [SLOT_W-1:0] slot_num,
  output logic [2:0]        fetch_kind,
  output logic              fetch_strobe,
  output logic              vblank,
  output logic              vbl_irq,
  output logic              dummy_line
);

  localparam int IDLE_LINE = NLINES - 1;

  // Internal events, named for the checks below.
  logic        line_end;
  logic        slot_first;
  logic        trim;
  logic        in_dummy;
  logic        in_visible;
  logic        blank_start;
  logic        dummy_start;
  logic        line_first;
  fetch_kind_t kind;

  assign line_first = (dot_num == '0);

  raster_dot_counter #(
    .SLOT_CYCLES (SLOT_CYCLES),
    .NSLOTS      (NSLOTS),
    .LINE_CYCLES (LINE_CYCLES),
    .TRIM_CYCLES (IDLE_CYCLES),
    .DOT_W       (DOT_W),
    .SLOT_W      (SLOT_W)
  ) u_dot (
    .clk        (clk),
    .rst_n      (rst_n),
    .trim       (trim),
    .dot        (dot_num),
    .slot       (slot_num),
    .slot_first (slot_first),
    .line_end   (line_end)
  );

  raster_line_counter #(
    .VBL_LINES (VBL_LINES),
    .VIS_LINES (VIS_LINES),
    .NLINES    (NLINES),
    .LINE_W    (LINE_W)
  ) u_line (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_end    (line_end),
    .line_first  (line_first),
    .render_en   (render_en),
    .line        (line_num),
    .in_dummy    (in_dummy),
    .in_visible  (in_visible),
    .blank_start (blank_start),
    .dummy_start (dummy_start),
    .trim        (trim)
  );

  raster_slot_decoder #(
    .BG_GROUPS  (BG_GROUPS),
    .SPR_GROUPS (SPR_GROUPS),
    .PRE_GROUPS (PRE_GROUPS),
    .TAIL_NAMES (TAIL_NAMES),
    .SLOT_W     (SLOT_W)
  ) u_dec (
    .render_en  (render_en),
    .fetch_line (in_dummy || in_visible),
    .slot       (slot_num),
    .slot_first (slot_first),
    .kind       (kind),
    .strobe     (fetch_strobe)
  );

  raster_vblank u_vbl (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_evt     (blank_start),
    .dummy_start (dummy_start),
    .clear_req   (vbl_clear),
    .irq_en      (irq_en),
    .flag        (vblank),
    .irq         (vbl_irq)
  );

  assign fetch_kind = kind;
  assign dummy_line = in_dummy;

  AST_NO_FETCH_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (line_num < LINE_W'(VBL_LINES) || line_num == LINE_W'(IDLE_LINE)) |-> (kind == FK_IDLE && !fetch_strobe)); // R6
  AST_NO_FETCH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !render_en |-> (kind == FK_IDLE && !fetch_strobe)); // R7
  AST_SHORT_ONLY_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && dot_num != DOT_W'(LINE_CYCLES - 1)) |-> in_dummy); // R8
  AST_TAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_num == SLOT_W'(NSLOTS)) |-> (kind == FK_IDLE)); // R5

  generate
    if (SLOT_CYCLES > 1) begin : g_strobe_gap
      AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_strobe |=> !fetch_strobe); // R2
    end
  endgenerate

endmodule

// File: tb/raster_fetch_seq_test.sv
module raster_fetch_seq_test;

  localparam int VBL   = 3;
  localparam int VIS   = 4;
  localparam int NL    = VBL + VIS + 2;
  localparam int DUM   = VBL;
  localparam int IDL   = NL - 1;
  localparam int FULL  = 1364;
  localparam int SHORT = 1360;
  localparam int LW    = $clog2(NL);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          render_en = 1'b1;
  logic          irq_en = 1'b1;
  logic          vbl_clear = 1'b0;
  logic [LW-1:0] line_num;
  logic [10:0]   dot_num;
  logic [7:0]    slot_num;
  logic [2:0]    fetch_kind;
  logic          fetch_strobe;
  logic          vblank;
  logic          vbl_irq;
  logic          dummy_line;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  raster_fetch_seq #(.VBL_LINES(VBL), .VIS_LINES(VIS)) uut (
    .clk(clk), .rst_n(rst_n), .render_en(render_en), .irq_en(irq_en),
    .vbl_clear(vbl_clear), .line_num(line_num), .dot_num(dot_num),
    .slot_num(slot_num), .fetch_kind(fetch_kind), .fetch_strobe(fetch_strobe),
    .vblank(vblank), .vbl_irq(vbl_irq), .dummy_line(dummy_line)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cyc++;
  endtask

  // Slot table restated as ranges of dots.
  function automatic int exp_kind(int d);
    int s;
    int g;
    if (d >= 1360) return 0;
    s = d / 8;
    g = s % 4;
    if (s < 128) return 1 + g;
    if (s < 160) return (g < 2) ? 6 : 5;
    if (s < 168) return 1 + g;
    return 1;
  endfunction

  function automatic int exp_slot(int d);
    return (d < 1360) ? d / 8 : 170;
  endfunction

  task automatic walk_line(input int l, input int len, input bit fetching, input string tag);
    for (int d = 0; d < len; d++) begin
      int ek;
      ek = fetching ? exp_kind(d) : 0;
      check(int'(line_num) == l, "R6 line number", int'(line_num), l);
      check(int'(dot_num) == d, "R1 dot count", int'(dot_num), d);
      check(int'(slot_num) == exp_slot(d), "R2 slot index", int'(slot_num), exp_slot(d));
      check(int'(fetch_kind) == ek, tag, int'(fetch_kind), ek);
      check(fetch_strobe == (ek != 0 && d % 8 == 0), "R2 fetch strobe", int'(fetch_strobe),
            int'(ek != 0 && d % 8 == 0));
      check(dummy_line == (l == DUM), "R6 dummy_line", int'(dummy_line), int'(l == DUM));
      tick();
    end
  endtask

  task automatic wait_pos(input int l, input int d);
    for (int i = 0; i < 20000; i++) begin
      if (int'(line_num) == l && int'(dot_num) == d) return;
      tick();
    end
    check(1'b0, "R1 position reached", int'(line_num), l);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    check(line_num == '0, "R11 reset line", int'(line_num), 0);
    check(dot_num == '0, "R11 reset dot", int'(dot_num), 0);
    check(slot_num == '0, "R11 reset slot", int'(slot_num), 0);
    check(!vblank, "R11 reset vblank", int'(vblank), 0);
    check(!vbl_irq, "R11 reset irq", int'(vbl_irq), 0);
    check(fetch_kind == 3'd0, "R11 R6 reset no fetch", int'(fetch_kind), 0);
    rst_n = 1'b1;
    cyc = 0;
  endtask

  // First frame, rendered, even parity: full dummy line, then flag and irq.
  task automatic t_first_frame();
    for (int l = 0; l < VBL; l++) walk_line(l, FULL, 1'b0, "R6 no fetch in vertical interval");
    walk_line(DUM, FULL, 1'b1, "R3 R4 R5 fetch kind dummy");
    for (int l = DUM + 1; l < IDL; l++) walk_line(l, FULL, 1'b1, "R3 R4 R5 fetch kind visible");
    walk_line(IDL, FULL, 1'b0, "R6 no fetch on idle line");
    check(cyc == NL * FULL, "R1 frame length", cyc, NL * FULL);
    check(int'(line_num) == 0 && dot_num == '0, "R1 frame wrap", int'(line_num), 0);
    check(vblank, "R9 flag set after idle line", int'(vblank), 1);
    check(vbl_irq, "R10 irq pulse", int'(vbl_irq), 1);
  endtask

  task automatic t_vblank_clear();
    tick();
    check(!vbl_irq, "R10 irq lasts one cycle", int'(vbl_irq), 0);
    check(vblank, "R9 flag held", int'(vblank), 1);
    repeat (50) tick();
    check(vblank, "R9 flag held without clear", int'(vblank), 1);
    vbl_clear = 1'b1;
    tick();
    vbl_clear = 1'b0;
    check(!vblank, "R9 flag cleared by vbl_clear", int'(vblank), 0);
  endtask

  // Second rendered frame has odd parity: dummy line is trimmed.
  task automatic t_short_dummy(input int frame_start);
    wait_pos(DUM, 0);
    walk_line(DUM, SHORT, 1'b1, "R8 R3 R4 R5 trimmed dummy kind");
    check(int'(line_num) == DUM + 1 && dot_num == '0, "R8 trimmed dummy length",
          int'(dot_num), 0);
    irq_en = 1'b0;
    wait_pos(IDL, FULL - 1);
    check(!vblank, "R9 flag low before set", int'(vblank), 0);
    tick();
    check(vblank, "R9 flag set", int'(vblank), 1);
    check(!vbl_irq, "R10 irq masked", int'(vbl_irq), 0);
    check(cyc - frame_start == NL * FULL - 4, "R8 trimmed frame length",
          cyc - frame_start, NL * FULL - 4);
    repeat (3) tick();
    check(!vbl_irq, "R10 irq stays low when masked", int'(vbl_irq), 0);
  endtask

  // Rendering off: no fetches, full dummy, parity unchanged.
  task automatic t_disabled_frame();
    wait_pos(DUM - 1, FULL - 1);
    check(vblank, "R9 flag held to dummy start", int'(vblank), 1);
    render_en = 1'b0;
    tick();
    check(!vblank, "R9 flag cleared at dummy start", int'(vblank), 0);
    walk_line(DUM, FULL, 1'b0, "R7 no fetch while disabled");
    for (int l = DUM + 1; l < IDL; l++) walk_line(l, FULL, 1'b0, "R7 no fetch while disabled");
    render_en = 1'b1;
    walk_line(IDL, FULL, 1'b0, "R6 no fetch on idle line");
  endtask

  task automatic t_after_disabled();
    wait_pos(DUM, 0);
    walk_line(DUM, FULL, 1'b1, "R8 parity held over unrendered frame");
    check(int'(line_num) == DUM + 1 && dot_num == '0, "R8 full dummy after unrendered frame",
          int'(line_num), DUM + 1);
  endtask

  initial begin
    int f2;
    #1;
    t_reset();
    t_first_frame();
    f2 = cyc;
    t_vblank_clear();
    t_short_dummy(f2);
    t_disabled_frame();
    t_after_disabled();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected 0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule